// File: doc/BRIEF.md
# Scrambled-Storage Four-Input Lookup Cell

This block is a single four-input lookup cell of the kind found in programmable logic fabric. Sixteen configuration bits select one of every possible Boolean function of four logical inputs. The bits are not held in truth-table order. The logical inputs pass through a fixed pin permutation onto internal select pins, and the stored word is addressed by those internal pins. A polarity mode can also hold every bit in complemented form. Whoever builds the configuration word must therefore scramble, and possibly invert, the intended truth table before loading it.

Configuration enters one bit per clock on a serial port, most significant bit first. A parallel readback port shows the physical word exactly as it was shifted in. The cell output is combinational from the four select inputs. It is held low until a complete sixteen-bit word has arrived since the start of the most recent load burst.

Top module: `lut4_scrambled_cell`

## Requirements
- R1: While reset is active, and directly after it, the readback word is 16'h0000, the output is 0, and the polarity mode is true (not inverted).
- R2: On every clock edge at which `cfg_load_en` is 1, the stored word shifts left by one and `cfg_sdi` enters bit 0. After sixteen such edges, the first bit sent sits in bit 15. The stored word does not change on edges at which `cfg_load_en` is 0.
- R3: The output is 0 whenever fewer than sixteen shift edges have occurred since the first edge of the current load burst. This covers a burst that stops early and a new burst that has only begun.
- R4: The logical select bits are routed to the internal address as {sel[1], sel[0], sel[3], sel[2]} (internal bit 3 down to bit 0). Logical entry 7 is therefore held in stored bit 13.
- R5: In true polarity the output equals the stored bit at the internal address. The logical table 16'h2A0A is realized by the stored word 16'h50D0.
- R6: In inverted polarity the output is the complement of the stored bit at the internal address. A logical table with only entry 7 set is realized by the stored word 16'hDFFF.
- R7: The polarity mode is taken from `cfg_invert` (1 = inverted) on the first edge of a load burst. The value of `cfg_invert` on any other edge has no effect on the output.
- R8: `cfg_readback` shows the stored word as shifted in, with no reordering and no inversion, in both polarity modes.
- R9: If a burst lasts longer than sixteen edges, shifting continues. The cell stays configured, and the last sixteen bits sent define the function.
- R10: Once configured, the output follows a change of the select inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration shifter |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load_en | input | 1 | Shift enable; a rising level starts a new load burst |
| cfg_sdi | input | 1 | Serial configuration data, most significant bit first |
| cfg_invert | input | 1 | Polarity request, taken on the first edge of a burst |
| lut_sel | input | 4 | Logical select inputs, bit 0 is the least significant address bit |
| lut_out | output | 1 | Combinational cell output |
| cfg_readback | output | 16 | Stored physical word |

## Verification
The assertions assume that the control inputs are settled at every rising clock edge. They also assume that the select inputs are known whenever the cell is configured, so the mux-tree output can be compared with the stored bit at the routed address. The stimulus meets these assumptions. All control inputs and select values are driven only in the low phase of the clock, after a falling edge, and each select sweep finishes before the next rising edge. The polarity input is toggled only in the middle of a burst or between bursts, so the rule that it is taken once per burst is exercised without breaking those assumptions.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;

  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_INV  = 1'b1
  } lc_pol_e;

  // Output polarity correction applied after the selection tree.
  function automatic logic lc_apply_pol(input logic raw, input lc_pol_e pol);
    return raw ^ (pol == POL_INV);
  endfunction

endpackage

// File: rtl/lc_cfg_shift.sv
module lc_cfg_shift #(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_en,
  input  logic                     sdi,
  input  logic                     invert_req,
  output logic [DEPTH-1:0]         word_q,
  output lut_cell_pkg::lc_pol_e    pol_q,
  output logic                     burst_start,
  output logic                     done
);
  import lut_cell_pkg::*;

  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic [CNTW-1:0] cnt_q;
  logic            en_prev_q;

  assign burst_start = load_en && !en_prev_q;
  assign done        = (cnt_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q    <= '0;
      cnt_q     <= '0;
      pol_q     <= POL_TRUE;
      en_prev_q <= 1'b0;
    end else begin
      en_prev_q <= load_en;
      if (load_en) begin
        word_q <= {word_q[DEPTH-2:0], sdi};
        if (burst_start) begin
          cnt_q <= CNTW'(1);
          pol_q <= lc_pol_e'(invert_req);
        end else if (!done) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lc_pin_perm.sv
module lc_pin_perm #(
  parameter int                      NUM_IN  = 4,
  parameter int                      MAP_W   = 2,
  parameter logic [NUM_IN*MAP_W-1:0] PIN_MAP = 8'b01_00_11_10
) (
  input  logic [NUM_IN-1:0] sel,
  output logic [NUM_IN-1:0] addr
);

  // Logical input i drives internal address bit PIN_MAP[i].
  for (genvar i = 0; i < NUM_IN; i++) begin : g_route
    assign addr[PIN_MAP[i*MAP_W +: MAP_W]] = sel[i];
  end

endmodule

// File: rtl/lc_mux_tree.sv
module lc_mux_tree #(
  parameter int NUM_IN = 4
) (
  input  logic [(1<<NUM_IN)-1:0] leaves,
  input  logic [NUM_IN-1:0]      addr,
  output logic                   y
);

  localparam int DEPTH = 1 << NUM_IN;

  // Level l holds DEPTH>>(l+1) two-to-one muxes steered by addr[l].
  for (genvar l = 0; l < NUM_IN; l++) begin : g_lvl
    localparam int W = DEPTH >> (l + 1);
    logic [W-1:0] nodes;
    for (genvar p = 0; p < W; p++) begin : g_mux
      if (l == 0) begin : g_leaf
        assign nodes[p] = addr[0] ? leaves[2*p+1] : leaves[2*p];
      end else begin : g_inner
        assign nodes[p] = addr[l] ? g_lvl[l-1].nodes[2*p+1]
                                  : g_lvl[l-1].nodes[2*p];
      end
    end
  end

  assign y = g_lvl[NUM_IN-1].nodes[0];

endmodule

// File: rtl/lut4_scrambled_cell.sv
module lut4_scrambled_cell #(
  parameter int                      NUM_IN  = 4,
  parameter int                      MAP_W   = 2,
  parameter logic [NUM_IN*MAP_W-1:0] PIN_MAP = 8'b01_00_11_10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_load_en,
  input  logic                     cfg_sdi,
  input  logic                     cfg_invert,
  input  logic [NUM_IN-1:0]        lut_sel,
  output logic                     lut_out,
  output logic [(1<<NUM_IN)-1:0]   cfg_readback
);
  import lut_cell_pkg::*;

  localparam int DEPTH = 1 << NUM_IN;

  logic [DEPTH-1:0]  word_q;
  lc_pol_e           pol_q;
  logic              burst_start;
  logic              cfg_done;
  logic [NUM_IN-1:0] phys_addr;
  logic              tree_y;

  lc_cfg_shift #(.DEPTH(DEPTH)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (cfg_load_en),
    .sdi         (cfg_sdi),
    .invert_req  (cfg_invert),
    .word_q      (word_q),
    .pol_q       (pol_q),
    .burst_start (burst_start),
    .done        (cfg_done)
  );

  lc_pin_perm #(.NUM_IN(NUM_IN), .MAP_W(MAP_W), .PIN_MAP(PIN_MAP)) u_perm (
    .sel  (lut_sel),
    .addr (phys_addr)
  );

  lc_mux_tree #(.NUM_IN(NUM_IN)) u_tree (
    .leaves (word_q),
    .addr   (phys_addr),
    .y      (tree_y)
  );

  assign cfg_readback = word_q;
  assign lut_out      = cfg_done && lc_apply_pol(tree_y, pol_q);

endmodule

// File: rtl/lut4_scrambled_cell_checker.sv
module lut4_scrambled_cell_checker #(
  parameter int NUM_IN = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_load_en,
  input logic                    cfg_sdi,
  input logic                    lut_out,
  input logic [(1<<NUM_IN)-1:0]  cfg_readback,
  input logic                    pol_inv,
  input logic                    burst_start,
  input logic                    cfg_done,
  input logic [NUM_IN-1:0]       phys_addr
);
  localparam int DEPTH = 1 << NUM_IN;

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (cfg_readback == '0) && !pol_inv && !cfg_done);

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load_en |=> (cfg_readback[0] == $past(cfg_sdi)) &&
                    (cfg_readback[DEPTH-1:1] == $past(cfg_readback[DEPTH-2:0])));

  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> $stable(cfg_readback));

  a_r3_out_low_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_done |-> !lut_out);

  a_r3_burst_unconfigures: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !cfg_done);

  a_r6_out_vs_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> (lut_out == (cfg_readback[phys_addr] ^ pol_inv)));

  a_r7_pol_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load_en |=> $stable(pol_inv));

  a_r7_pol_midburst_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load_en && !burst_start) |=> $stable(pol_inv));

  a_r9_stays_configured: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_done && cfg_load_en && !burst_start) |=> cfg_done);

endmodule

bind lut4_scrambled_cell lut4_scrambled_cell_checker #(.NUM_IN(NUM_IN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_load_en  (cfg_load_en),
  .cfg_sdi      (cfg_sdi),
  .lut_out      (lut_out),
  .cfg_readback (cfg_readback),
  .pol_inv      (pol_q == lut_cell_pkg::POL_INV),
  .burst_start  (burst_start),
  .cfg_done     (cfg_done),
  .phys_addr    (phys_addr)
);

// File: tb/lut4_scrambled_cell_bench.sv
`timescale 1ns/10ps
module lut4_scrambled_cell_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load_en = 1'b0;
  logic        cfg_sdi = 1'b0;
  logic        cfg_invert = 1'b0;
  logic [3:0]  lut_sel = 4'h0;
  logic        lut_out;
  logic [15:0] cfg_readback;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lut4_scrambled_cell u_lut4_scrambled_cell (
    .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_sdi(cfg_sdi),
    .cfg_invert(cfg_invert), .lut_sel(lut_sel), .lut_out(lut_out),
    .cfg_readback(cfg_readback)
  );

  // Vector table: {invert, logical truth table}
  localparam logic [16:0] VEC [6] = '{
    {1'b0, 16'h2A0A}, {1'b1, 16'h0080}, {1'b0, 16'h0080},
    {1'b1, 16'hA5C3}, {1'b0, 16'hFFFF}, {1'b1, 16'h1234}
  };

  // Internal address a = {I1,I0,I3,I2}; so logical k = {a[1],a[0],a[3],a[2]}.
  function automatic logic [15:0] to_phys(input logic [15:0] tt);
    logic [15:0] w;
    for (int a = 0; a < 16; a++) begin
      logic [3:0] av;
      av = 4'(a);
      w[a] = tt[{av[1], av[0], av[3], av[2]}];
    end
    return w;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Shifts the low n bits of seq, most significant first; optional polarity flip after first bit.
  task automatic load_seq(input logic [31:0] seq, input int n, input logic inv, input bit flip);
    for (int b = n - 1; b >= 0; b--) begin
      @(negedge clk);
      cfg_load_en = 1'b1;
      cfg_sdi     = seq[b];
      cfg_invert  = (flip && b != n - 1) ? ~inv : inv;
    end
    @(negedge clk);
    cfg_load_en = 1'b0;
  endtask

  // Sweeps all selects within one low clock phase.
  task automatic sweep(input logic [15:0] exp_tt, input string req);
    for (int s = 0; s < 16; s++) begin
      lut_sel = 4'(s);
      #0.1;
      chk({15'b0, lut_out}, {15'b0, exp_tt[s]}, req);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [15:0] phys;
    repeat (3) @(negedge clk);
    chk(cfg_readback, 16'h0000, "R1 readback in reset");
    chk({15'b0, lut_out}, 16'h0, "R1 output in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_readback, 16'h0000, "R1 readback after reset");
    sweep(16'h0000, "R3 unconfigured output low");

    // Table-driven walk
    for (int v = 0; v < 6; v++) begin
      phys = VEC[v][16] ? ~to_phys(VEC[v][15:0]) : to_phys(VEC[v][15:0]);
      load_seq({16'h0, phys}, 16, VEC[v][16], 1'b0);
      chk(cfg_readback, phys, "R2 R8 readback of shifted word");
      sweep(VEC[v][15:0], VEC[v][16] ? "R6 inverted output" : "R5 true output");
    end

    // Literal mapping points
    chk(to_phys(16'h2A0A), 16'h50D0, "R5 bench mapping 2A0A");
    load_seq({16'h0, 16'h50D0}, 16, 1'b0, 1'b0);
    sweep(16'h2A0A, "R5 literal 50D0");
    load_seq({16'h0, 16'hDFFF}, 16, 1'b1, 1'b0);
    chk(cfg_readback, 16'hDFFF, "R8 inverted word raw");
    sweep(16'h0080, "R6 literal DFFF");
    load_seq({16'h0, 16'h2000}, 16, 1'b0, 1'b0);
    lut_sel = 4'd7; #0.1;
    chk({15'b0, lut_out}, 16'h1, "R4 entry 7 at stored bit 13");
    lut_sel = 4'd13; #0.1;
    chk({15'b0, lut_out}, 16'h0, "R4 entry 13 not at bit 13");

    // R10: output follows select changes with no edge in between
    load_seq({16'h0, to_phys(16'h00FF)}, 16, 1'b0, 1'b0);
    lut_sel = 4'd3; #0.3;
    chk({15'b0, lut_out}, 16'h1, "R10 combinational low half");
    lut_sel = 4'd12; #0.3;
    chk({15'b0, lut_out}, 16'h0, "R10 combinational high half");

    // R3: a 15-bit burst leaves the cell unconfigured
    phys = cfg_readback;
    load_seq({17'h0, 15'h5A5A}, 15, 1'b0, 1'b0);
    chk(cfg_readback, {phys[0], 15'h5A5A}, "R2 partial shift");
    sweep(16'h0000, "R3 partial burst output low");

    // R7: polarity toggled after the first bit is ignored
    load_seq({16'h0, ~to_phys(16'h6C39)}, 16, 1'b1, 1'b1);
    sweep(16'h6C39, "R7 polarity from first edge");
    cfg_invert = 1'b0;
    load_seq({16'h0, to_phys(16'h0F0F)}, 16, 1'b0, 1'b0);
    @(negedge clk); cfg_invert = 1'b1;
    @(negedge clk); cfg_invert = 1'b0;
    @(negedge clk);
    sweep(16'h0F0F, "R7 idle polarity change ignored");
    chk(cfg_readback, to_phys(16'h0F0F), "R2 idle hold");

    // R9: over-long burst keeps the last sixteen bits
    load_seq({12'h0, 4'hA, to_phys(16'h9AC1)}, 20, 1'b0, 1'b0);
    chk(cfg_readback, to_phys(16'h9AC1), "R9 last sixteen bits kept");
    sweep(16'h9AC1, "R9 configured after long burst");

    // R1 again: mid-life reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_readback, 16'h0000, "R1 readback after second reset");
    sweep(16'h0000, "R1 output after second reset");

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule